// File: doc/BRIEF.md
# Debug Request Acknowledge Controller

This block sits between an external debug-event pin and the CPU's halt logic. It watches an active-low request line that arrives asynchronously. When debug is enabled and the line falls, the block asks the CPU to stop at its next instruction boundary. When the CPU reports that it has halted, the block drives an enable for a fixed number of clocks. That enable is meant to switch on the open-drain pulldown of the shared event pin, which tells the external controller that the halt was accepted.

The block also keeps an active-low flag that other on-chip units read to learn that a debug session is open. The flag drops the first time the CPU halts. It then stays low through every halt and resume of single-stepping. It rises again only when a command write carries both the go and execute bits and selects either the "no register" code or the CPU scan-chain code.

All pins are plain control and status levels, plus one single-cycle command strobe. No data moves through the block, so no pin has a valid/ready handshake and none can apply back-pressure. A command strobe is taken in the cycle it is high.

Top module: `dbg_handshake_ctrl`

## Requirements
- R1: With `dbg_enable` high, a high-to-low transition of `dbg_req_n` drives `halt_req` high at the third rising clock after the transition. Two synchroniser stages come first, then an edge detector and then a register.
- R2: While `dbg_enable` is low, a fall of `dbg_req_n` leaves `halt_req` low. Raising `dbg_enable` while `dbg_req_n` is already held low does not raise `halt_req` either.
- R3: `halt_req` goes low in the cycle after `cpu_halted` is first seen high. A request line that stays low afterwards does not raise it again. A new request is taken only from a fresh high-to-low transition that follows the end of the acknowledge pulse.
- R4: On each rising edge of `cpu_halted` seen while `dbg_enable` is high, `ack_oe` is high for exactly `ACK_CYCLES` clocks (3 by default). The pulse starts in the cycle after the edge. An entry while `dbg_enable` is low gives no pulse.
- R5: If `cpu_halted` falls before the pulse ends, `ack_oe` still stays high for its full length.
- R6: `session_n` goes low in the cycle after the first rising edge of `cpu_halted`. It stays low while the CPU leaves and re-enters the halted state.
- R7: `session_n` goes high in the cycle after a write (`cmd_wr` high) with `cmd_go`=1, `cmd_ex`=1, `dbg_enable`=1, and `cmd_sel` equal to `SEL_NONE` (default 7'h7F) or `SEL_SCR` (default 7'h10).
- R8: Some writes leave `session_n` low:
  - a write with go but without execute;
  - a go+execute write to any other select code (for example 7'h05);
  - any write while `dbg_enable` is low.
- R9: While `rst_n` is low, `halt_req` and `ack_oe` are low and `session_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_enable | input | 1 | Debug operations allowed |
| dbg_req_n | input | 1 | Asynchronous active-low debug request |
| cpu_halted | input | 1 | CPU is in the debug (halted) state |
| halt_req | output | 1 | Request to the CPU to halt into debug mode |
| cmd_wr | input | 1 | Single-cycle command-register write strobe |
| cmd_go | input | 1 | Go bit of the written command |
| cmd_ex | input | 1 | Execute (exit) bit of the written command |
| cmd_sel | input | SEL_W | Register select of the written command |
| ack_oe | output | 1 | Acknowledge enable for the pin pulldown |
| session_n | output | 1 | Active-low debug-session-in-progress flag |

## Verification
Three request patterns are tried, and each separates a different failure:
- A fall while enabled checks the latency.
- A fall while disabled, followed by enabling with the line still held low, separates level sensing from edge sensing.
- A line held low across the acknowledge, followed by a fresh high-to-low cycle, separates a re-arming handshake from one that re-triggers.

The acknowledge is checked on a full halt, on a halt the CPU leaves after one clock, and on a halt while disabled. The session flag is driven with:
- a go-only write;
- a go+execute write to an unrelated select code;
- a write while disabled;
- the two releasing select codes.

Only the last two kinds of write should raise the flag.

// File: rtl/dbgh_pkg.sv
package dbgh_pkg;

  typedef enum logic [1:0] {
    HS_ARMED   = 2'd0,
    HS_PENDING = 2'd1,
    HS_ACKWAIT = 2'd2
  } hs_state_e;

  typedef struct packed {
    logic wr;
    logic go;
    logic ex;
  } cmd_ctl_t;

endpackage

// File: rtl/dbgh_req_sync.sv
module dbgh_req_sync #(
  parameter int STAGES = 2
) (
  input  logic tck,
  input  logic rst_n,
  input  logic async_n,
  output logic fall
);
  // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
        chain[g] <= 1'b1;
      end else if (g == 0) begin
        chain[g] <= async_n;
      end else begin
        chain[g] <= chain[g-1];
      end
    end
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/dbgh_req_fsm.sv
module dbgh_req_fsm
  import dbgh_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic req_fall,
  input  logic enable,
  input  logic entry,
  input  logic ack_busy,
  output logic halt_req
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_ARMED:   if (req_fall && enable) state_d = HS_PENDING;
      HS_PENDING: if (entry)              state_d = HS_ACKWAIT;
      HS_ACKWAIT: if (!ack_busy)          state_d = HS_ARMED;
      default:                            state_d = HS_ARMED;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= HS_ARMED;
    else        state_q <= state_d;
  end

  assign halt_req = (state_q == HS_PENDING);
endmodule

// File: rtl/dbgh_ack_pulse.sv
module dbgh_ack_pulse #(
  parameter int LEN = 3
) (
  input  logic tck,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;      // a running pulse always finishes
    end else if (start) begin
      cnt_q <= LOAD;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dbgh_session.sv
module dbgh_session (
  input  logic tck,
  input  logic rst_n,
  input  logic entry,
  input  logic release_cmd,
  output logic session_n
);
  logic active_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)           active_q <= 1'b0;
    else if (entry)       active_q <= 1'b1;   // a new halt outranks a release
    else if (release_cmd) active_q <= 1'b0;
  end

  assign session_n = ~active_q;
endmodule

// File: rtl/dbg_handshake_ctrl.sv
module dbg_handshake_ctrl
  import dbgh_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              ACK_CYCLES  = 3,
  parameter int              SEL_W       = 7,
  parameter logic [SEL_W-1:0] SEL_NONE   = 7'h7F,
  parameter logic [SEL_W-1:0] SEL_SCR    = 7'h10
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             dbg_enable,
  input  logic             dbg_req_n,
  input  logic             cpu_halted,
  output logic             halt_req,
  input  logic             cmd_wr,
  input  logic             cmd_go,
  input  logic             cmd_ex,
  input  logic [SEL_W-1:0] cmd_sel,
  output logic             ack_oe,
  output logic             session_n
);
  logic     req_fall;
  logic     halted_q;
  logic     entry;
  logic     sel_ok;
  logic     release_cmd;
  cmd_ctl_t ctl;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) halted_q <= 1'b0;
    else        halted_q <= cpu_halted;
  end

  assign entry = cpu_halted & ~halted_q;

  assign ctl         = '{wr: cmd_wr, go: cmd_go, ex: cmd_ex};
  assign sel_ok      = (cmd_sel == SEL_NONE) || (cmd_sel == SEL_SCR);
  assign release_cmd = ctl.wr & ctl.go & ctl.ex & sel_ok & dbg_enable;

  dbgh_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .tck     (tck),
    .rst_n   (rst_n),
    .async_n (dbg_req_n),
    .fall    (req_fall)
  );

  dbgh_req_fsm u_fsm (
    .tck      (tck),
    .rst_n    (rst_n),
    .req_fall (req_fall),
    .enable   (dbg_enable),
    .entry    (entry),
    .ack_busy (ack_oe),
    .halt_req (halt_req)
  );

  dbgh_ack_pulse #(.LEN(ACK_CYCLES)) u_ack (
    .tck   (tck),
    .rst_n (rst_n),
    .start (entry & dbg_enable),
    .busy  (ack_oe)
  );

  dbgh_session u_sess (
    .tck         (tck),
    .rst_n       (rst_n),
    .entry       (entry),
    .release_cmd (release_cmd),
    .session_n   (session_n)
  );
endmodule

// File: rtl/dbgh_checker.sv
module dbgh_checker #(
  parameter int               ACK_CYCLES = 3,
  parameter int               SEL_W      = 7,
  parameter logic [SEL_W-1:0] SEL_NONE   = 7'h7F,
  parameter logic [SEL_W-1:0] SEL_SCR    = 7'h10
) (
  input logic             tck,
  input logic             rst_n,
  input logic             dbg_enable,
  input logic             cpu_halted,
  input logic             halt_req,
  input logic             cmd_wr,
  input logic             cmd_go,
  input logic             cmd_ex,
  input logic [SEL_W-1:0] cmd_sel,
  input logic             ack_oe,
  input logic             session_n
);
  logic [7:0] run_q;
  logic       rel;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (ack_oe) run_q <= run_q + 8'd1;
    else             run_q <= '0;
  end

  assign rel = cmd_wr && cmd_go && cmd_ex && dbg_enable &&
               ((cmd_sel == SEL_NONE) || (cmd_sel == SEL_SCR));

  p_halt_needs_en_r2: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(halt_req) |-> $past(dbg_enable));

  p_halt_drops_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (halt_req && cpu_halted) |=> !halt_req);

  p_ack_length_r4: assert property (@(posedge tck) disable iff (!rst_n)
    $fell(ack_oe) |-> (run_q == 8'(ACK_CYCLES)));

  p_sess_opens_r6: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(cpu_halted) |=> !session_n);

  p_sess_closes_r7: assert property (@(posedge tck) disable iff (!rst_n)
    (rel && !cpu_halted) |=> session_n);

  p_sess_holds_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (!session_n && !rel) |=> !session_n);

  p_reset_vals_r9: assert property (@(posedge tck)
    !rst_n |-> (!halt_req && !ack_oe && session_n));
endmodule

bind dbg_handshake_ctrl dbgh_checker #(
  .ACK_CYCLES (ACK_CYCLES),
  .SEL_W      (SEL_W),
  .SEL_NONE   (SEL_NONE),
  .SEL_SCR    (SEL_SCR)
) u_chk (
  .tck        (tck),
  .rst_n      (rst_n),
  .dbg_enable (dbg_enable),
  .cpu_halted (cpu_halted),
  .halt_req   (halt_req),
  .cmd_wr     (cmd_wr),
  .cmd_go     (cmd_go),
  .cmd_ex     (cmd_ex),
  .cmd_sel    (cmd_sel),
  .ack_oe     (ack_oe),
  .session_n  (session_n)
);

// File: tb/sim_dbg_handshake_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_handshake_ctrl;
  localparam int SIG_HALT = 0;
  localparam int SIG_ACK  = 1;
  localparam int SIG_SESS = 2;
  localparam logic [6:0] NONE = 7'h7F;
  localparam logic [6:0] SCR  = 7'h10;

  typedef struct {
    int    cyc;
    int    sig;
    bit    val;
    string rq;
  } exp_t;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_enable = 1'b0;
  logic dbg_req_n = 1'b1;
  logic cpu_halted = 1'b0;
  logic cmd_wr = 1'b0;
  logic cmd_go = 1'b0;
  logic cmd_ex = 1'b0;
  logic [6:0] cmd_sel = 7'h00;
  logic halt_req, ack_oe, session_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #10 tck = ~tck;   // 50 MHz
  always @(posedge tck) cyc <= cyc + 1;

  dbg_handshake_ctrl u0 (
    .tck(tck), .rst_n(rst_n), .dbg_enable(dbg_enable), .dbg_req_n(dbg_req_n),
    .cpu_halted(cpu_halted), .halt_req(halt_req), .cmd_wr(cmd_wr),
    .cmd_go(cmd_go), .cmd_ex(cmd_ex), .cmd_sel(cmd_sel),
    .ack_oe(ack_oe), .session_n(session_n)
  );

  task automatic tick(int n);
    repeat (n) @(negedge tck);
  endtask

  // driver side: schedule an expected value k negedges from now
  task automatic expect_in(int k, int sig, bit val, string rq);
    exp_t e;
    int i;
    e = '{cyc + k, sig, val, rq};
    i = 0;
    while (i < q.size() && q[i].cyc <= e.cyc) i++;
    q.insert(i, e);
  endtask

  task automatic cmd(bit go, bit ex, logic [6:0] sel);
    cmd_wr = 1'b1; cmd_go = go; cmd_ex = ex; cmd_sel = sel;
    tick(1);
    cmd_wr = 1'b0; cmd_go = 1'b0; cmd_ex = 1'b0;
  endtask

  // monitor side: pop and compare at each negedge
  always @(negedge tck) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      bit act;
      e = q.pop_front();
      case (e.sig)
        SIG_HALT: act = halt_req;
        SIG_ACK:  act = ack_oe;
        default:  act = session_n;
      endcase
      total++;
      if (act !== e.val) begin
        bad++;
        $display("FAIL %s sig=%0d cyc=%0d actual=%0b expected=%0b",
                 e.rq, e.sig, cyc, act, e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(1);
    expect_in(1, SIG_HALT, 1'b0, "R9");
    expect_in(1, SIG_ACK,  1'b0, "R9");
    expect_in(1, SIG_SESS, 1'b1, "R9");
    tick(3);
    rst_n = 1'b1; dbg_enable = 1'b1;
    tick(2);

    // R1: request latency
    dbg_req_n = 1'b0;
    expect_in(2, SIG_HALT, 1'b0, "R1");
    expect_in(3, SIG_HALT, 1'b1, "R1");
    tick(5);

    // CPU halts: halt_req drops, ack pulse, session opens
    cpu_halted = 1'b1;
    expect_in(1, SIG_HALT, 1'b0, "R3");
    expect_in(1, SIG_ACK,  1'b1, "R4");
    expect_in(3, SIG_ACK,  1'b1, "R4");
    expect_in(4, SIG_ACK,  1'b0, "R4");
    expect_in(1, SIG_SESS, 1'b0, "R6");
    tick(6);
    expect_in(2, SIG_HALT, 1'b0, "R3 held request");
    tick(3);
    dbg_req_n = 1'b1; cpu_halted = 1'b0;
    tick(1);
    expect_in(1, SIG_SESS, 1'b0, "R6 after exit");
    tick(3);

    // R8: non-releasing writes
    cmd(1'b1, 1'b0, NONE);
    expect_in(1, SIG_SESS, 1'b0, "R8 go only");
    cmd(1'b1, 1'b1, 7'h05);
    expect_in(1, SIG_SESS, 1'b0, "R8 other select");
    tick(2);

    // single-step re-entry with early exit (R5)
    cpu_halted = 1'b1;
    expect_in(1, SIG_ACK,  1'b1, "R4 re-entry");
    expect_in(2, SIG_SESS, 1'b0, "R6 re-entry");
    tick(1);
    cpu_halted = 1'b0;
    expect_in(2, SIG_ACK, 1'b1, "R5");
    expect_in(3, SIG_ACK, 1'b0, "R5");
    tick(5);

    // R7: release with no-register select
    cmd_wr = 1'b1; cmd_go = 1'b1; cmd_ex = 1'b1; cmd_sel = NONE;
    expect_in(1, SIG_SESS, 1'b1, "R7 none");
    tick(1);
    cmd_wr = 1'b0; cmd_go = 1'b0; cmd_ex = 1'b0;
    tick(3);

    cpu_halted = 1'b1;
    tick(1);
    cpu_halted = 1'b0;
    expect_in(1, SIG_SESS, 1'b0, "R6 second session");
    tick(5);
    cmd_wr = 1'b1; cmd_go = 1'b1; cmd_ex = 1'b1; cmd_sel = SCR;
    expect_in(1, SIG_SESS, 1'b1, "R7 scan chain");
    tick(1);
    cmd_wr = 1'b0; cmd_go = 1'b0; cmd_ex = 1'b0;
    tick(2);

    // R2: disabled request
    dbg_enable = 1'b0; dbg_req_n = 1'b0;
    expect_in(3, SIG_HALT, 1'b0, "R2 disabled");
    expect_in(5, SIG_HALT, 1'b0, "R2 disabled");
    tick(6);
    cpu_halted = 1'b1;
    expect_in(1, SIG_ACK,  1'b0, "R4 disabled entry");
    expect_in(1, SIG_SESS, 1'b0, "R6 disabled entry");
    tick(1);
    cpu_halted = 1'b0;
    tick(3);
    cmd(1'b1, 1'b1, NONE);
    expect_in(1, SIG_SESS, 1'b0, "R8 disabled write");
    tick(2);
    dbg_enable = 1'b1;
    expect_in(4, SIG_HALT, 1'b0, "R2 enable while held");
    tick(5);

    // R3: fresh edge after acknowledge re-arms
    dbg_req_n = 1'b1;
    tick(3);
    dbg_req_n = 1'b0;
    expect_in(3, SIG_HALT, 1'b1, "R3 new edge");
    tick(4);
    cpu_halted = 1'b1;
    expect_in(1, SIG_HALT, 1'b0, "R3");
    tick(6);
    cpu_halted = 1'b0; dbg_req_n = 1'b1;
    cmd(1'b1, 1'b1, SCR);
    expect_in(1, SIG_SESS, 1'b1, "R7 final");
    tick(4);

    while (q.size() > 0) tick(1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule